// File: doc/BRIEF.md
# Serial Configuration EEPROM Word Reader

This engine fetches 16-bit words from a three-wire serial configuration EEPROM. It owns the chip-select, serial-clock and data-in pins and listens on data-out. A one-cycle start pulse together with a word address launches a read. The engine shifts out a read command followed by the address bits, clocks in 16 data bits, and presents the word on `rdata` with a one-cycle `done` pulse. Each level of the serial clock lasts `DIV` system clocks.

Right after reset an internal sequencer performs four reads on its own. First it reads word 0 to find out how many address bits the attached device uses. It then reads words 7, 8 and 9, which hold the 48-bit station address, and packs them into `mac_addr`. The engine refuses user reads until that sequence has finished. Every later user read uses the address width that was detected.

Top module: `cfg_eeprom_reader`

## Requirements
- R1: While reset is asserted, `ee_cs`, `ee_sk`, `ee_di`, `done` and `mac_valid` are all low.
- R2: A read opens with one half-period in which `ee_cs` is high and `ee_sk` is low. `ee_sk` is never high while `ee_cs` is low.
- R3: The command has 3+W bits, where W is the address width (6 or 8). The first three bits are 1, 1, 0. The address follows, most significant bit first. With W=6 only `addr[5:0]` is sent. Each bit is placed on `ee_di` during a low half-period and held through the following high half-period.
- R4: After the command comes one low half-period. Then 16 high/low clock pairs follow. `ee_do` is sampled at the end of each high half-period, and the first sample becomes bit 15 of the word.
- R5: When the last data bit has been taken, `ee_cs` drops. In the following cycle `done` is high for exactly one cycle, `busy` is low and `rdata` holds the word.
- R6: Every half-period of `ee_sk` lasts exactly `DIV` clock cycles.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The transfer in progress and its result are unchanged.
- R8: After reset, word 0 is read with an 8-bit address. If it equals 0x8129, W is 8 from then on and `wide_addr` is 1. Otherwise W is 6 and `wide_addr` is 0.
- R9: Words 7, 8 and 9 are then read, each with width W. `mac_addr[47:40]`, `[39:32]`, `[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` receive, in that order, the low byte of word 7, its high byte, the low byte of word 8, its high byte, the low byte of word 9 and its high byte. `mac_valid` then rises and stays high until the next reset. The start-up reads produce no `done` pulse.
- R10: `busy` is high from the cycle after an accepted start until `done`. During the start-up sequence it stays high until the cycle after word 9 completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Read request pulse |
| addr | input | 8 | Word address; the upper two bits are unused in 6-bit mode |
| rdata | output | 16 | Last word read |
| done | output | 1 | One-cycle pulse when a user read completes |
| busy | output | 1 | Engine or start-up sequencer is active |
| wide_addr | output | 1 | 1 when the 8-bit address width was detected |
| mac_addr | output | 48 | Station address gathered at start-up |
| mac_valid | output | 1 | `mac_addr` is complete |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the engine with `DIV` = 3 and the default signature, with start-up loading enabled. Because each half-period then spans three clocks, a divider that is off by one, or a sample taken on the wrong edge, shifts the pin waveform away from the cycle-exact reference. The bench applies two resets, the first with 0x8129 stored in word 0 and the second without it. This exercises both command lengths, the masking of the upper address bits, and the station-address packing for both widths.

// File: rtl/cfg_eeprom_reader.sv
`timescale 1ns/1ps
module cfg_eeprom_reader #(
  parameter int          DIV      = 4,
  parameter logic [15:0] SIG      = 16'h8129,
  parameter bit          AUTOLOAD = 1'b1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  addr,
  output logic [15:0] rdata,
  output logic        done,
  output logic        busy,
  output logic        wide_addr,
  output logic [47:0] mac_addr,
  output logic        mac_valid,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int             DCW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DCW-1:0] DLAST   = DCW'(DIV - 1);
  localparam logic [2:0]     AL_DONE = 3'd4;

  logic           run;
  logic [DCW-1:0] dcnt;
  logic [6:0]     ph;
  logic [7:0]     a_q;
  logic           w_q;
  logic [15:0]    sh;
  logic [2:0]     al;
  logic           wide;
  logic [7:0]     go_addr;
  logic           go_w;

  wire        tick    = run && (dcnt == DLAST);
  wire [6:0]  ncmd    = w_q ? 7'd11 : 7'd9;
  wire [6:0]  cmd_end = ncmd << 1;
  wire [6:0]  last_ph = cmd_end + 7'd33;
  wire [10:0] cmd     = w_q ? {3'b110, a_q} : {2'b00, 3'b110, a_q[5:0]};
  wire [6:0]  bidx    = ncmd - 7'd1 - ((ph - 7'd1) >> 1);
  wire [10:0] cmd_sh  = cmd >> bidx;
  wire        in_cmd  = (ph != 7'd0) && (ph <= cmd_end);
  wire        hi_ph   = (ph != 7'd0) && !ph[0];
  wire        fin     = tick && (ph == last_ph);
  wire        smp     = tick && hi_ph && (ph > cmd_end);
  wire        al_go   = !run && (al != AL_DONE);
  wire        usr_go  = !run && (al == AL_DONE) && start;

  always_comb begin
    go_addr = addr;
    go_w    = wide;
    case (al)
      3'd0: begin go_addr = 8'd0; go_w = 1'b1; end
      3'd1: go_addr = 8'd7;
      3'd2: go_addr = 8'd8;
      3'd3: go_addr = 8'd9;
      default: ;
    endcase
  end

  assign ee_cs     = run;
  assign ee_sk     = run && hi_ph;
  assign ee_di     = run && in_cmd && cmd_sh[0];
  assign busy      = run || (al != AL_DONE);
  assign mac_valid = AUTOLOAD && (al == AL_DONE);
  assign wide_addr = wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      dcnt     <= '0;
      ph       <= '0;
      a_q      <= '0;
      w_q      <= 1'b0;
      sh       <= '0;
      al       <= AUTOLOAD ? 3'd0 : AL_DONE;
      wide     <= 1'b0;
      rdata    <= '0;
      done     <= 1'b0;
      mac_addr <= '0;
    end else begin
      done <= 1'b0;
      if (al_go || usr_go) begin
        run  <= 1'b1;
        dcnt <= '0;
        ph   <= '0;
        a_q  <= go_addr;
        w_q  <= go_w;
      end else if (run) begin
        dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) ph <= ph + 7'd1;
        if (smp)  sh <= {sh[14:0], ee_do};
        if (fin) begin
          run   <= 1'b0;
          rdata <= sh;
          done  <= (al == AL_DONE);
          if (al != AL_DONE) begin
            al <= al + 3'd1;
            case (al)
              3'd0:    wide            <= (sh == SIG);
              3'd1:    mac_addr[47:32] <= {sh[7:0], sh[15:8]};
              3'd2:    mac_addr[31:16] <= {sh[7:0], sh[15:8]};
              default: mac_addr[15:0]  <= {sh[7:0], sh[15:8]};
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_eeprom_reader_chk.sv
`timescale 1ns/1ps
module cfg_eeprom_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic        mac_valid,
  input logic [47:0] mac_addr
);
  assert_sk_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_cs_opens_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_sk);

  assert_di_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> $stable(ee_di));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !busy));

  assert_cs_means_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> busy);

  assert_mac_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |=> (mac_valid && $stable(mac_addr)));
endmodule

bind cfg_eeprom_reader cfg_eeprom_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ee_cs(ee_cs),
  .ee_sk(ee_sk), .ee_di(ee_di), .mac_valid(mac_valid), .mac_addr(mac_addr)
);

// File: tb/cfg_eeprom_reader_test.sv
`timescale 1ns/1ps
module cfg_eeprom_reader_test;
  localparam int DIV = 3;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  addr = 8'd0;
  logic [15:0] rdata;
  logic        done, busy, wide_addr, mac_valid, ee_cs, ee_sk, ee_di;
  logic [47:0] mac_addr;
  logic        ee_do = 1'b0;

  always #5 clk = ~clk;

  cfg_eeprom_reader #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .rdata(rdata),
    .done(done), .busy(busy), .wide_addr(wide_addr), .mac_addr(mac_addr),
    .mac_valid(mac_valid), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  int checks = 0, errors = 0;
  logic [15:0] mem [0:255];

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // reference model state
  bit          active = 0, go = 0;
  int          c = 0, al_stage = 4, cur_w = 8, exp_w = 6, tlen = 0;
  logic [7:0]  cur_addr = 8'd0;

  function automatic logic [2:0] exp_pins(int cc, int w, logic [7:0] a);
    int n = 3 + w;
    int p = cc / DIV;
    int cmd = (6 << w) | ((w == 8) ? int'(a) : int'(a & 8'h3F));
    if (p == 0) return 3'b100;
    if (p <= 2*n) begin
      int k = (p - 1) / 2;
      return {1'b1, ((p - 1) % 2) == 1, ((cmd >> (n - 1 - k)) & 1) == 1};
    end
    return {1'b1, ((p - 2*n - 1) % 2) == 1, 1'b0};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      active = 0; go = 0; al_stage = 0;
    end else begin
      if (go) begin active = 1; c = 0; go = 0; end
      if (active) begin
        tlen = (2*(3 + cur_w) + 34) * DIV;
        if (c < tlen) begin
          logic [2:0] e;
          e = exp_pins(c, cur_w, cur_addr);
          chk(ee_cs, e[2], "R2", "chip select");
          chk(ee_sk, e[1], "R6", "serial clock");
          chk(ee_di, e[0], "R3", "data in");
          chk(busy, 1'b1, "R10", "busy during read");
          chk(done, 1'b0, "R5", "done during read");
        end else begin
          active = 0;
          chk(ee_cs, 1'b0, "R5", "cs after read");
          if (al_stage < 4) begin
            chk(done, 1'b0, "R9", "no done on start-up read");
            if (al_stage == 0) exp_w = (mem[0] == 16'h8129) ? 8 : 6;
            al_stage++;
            chk(busy, al_stage < 4, "R10", "busy across start-up");
          end else begin
            chk(done, 1'b1, "R5", "done pulse");
            chk(busy, 1'b0, "R10", "busy released");
            chk(rdata, mem[cur_addr], "R4", "read word");
          end
        end
        c++;
      end
      if (!active && !go) begin
        if (al_stage < 4) begin
          go = 1;
          cur_addr = (al_stage == 0) ? 8'd0 : 8'(6 + al_stage);
          cur_w = (al_stage == 0) ? 8 : exp_w;
        end else if (start && !busy) begin
          go = 1;
          cur_w = exp_w;
          cur_addr = (exp_w == 8) ? addr : (addr & 8'h3F);
        end
      end
    end
  end

  // EEPROM device model
  int dev_cnt = 0, dev_addr = 0;
  logic [15:0] dev_word = 16'd0;
  always @(posedge ee_sk) if (ee_cs) begin
    int n;
    n = 3 + cur_w;
    dev_cnt++;
    if (dev_cnt > 3 && dev_cnt <= n) dev_addr = (dev_addr << 1) | int'(ee_di);
    if (dev_cnt == n) dev_word = mem[dev_addr];
    if (dev_cnt > n && dev_cnt <= n + 16) ee_do = dev_word[15 - (dev_cnt - n - 1)];
  end
  always @(negedge ee_cs) begin dev_cnt = 0; dev_addr = 0; ee_do = 1'b0; end

  function automatic logic [47:0] exp_mac();
    return {mem[7][7:0], mem[7][15:8], mem[8][7:0], mem[8][15:8], mem[9][7:0], mem[9][15:8]};
  endfunction

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic do_read(input logic [7:0] a);
    @(posedge clk); #1 start = 1'b1; addr = a;
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    chk(rdata, mem[(exp_w == 8) ? a : (a & 8'h3F)], "R4", "word via task");
  endtask

  task automatic do_reset(input logic [15:0] w0, input logic wide_exp);
    mem[0] = w0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, done}, 4'b0000, "R1", "pins in reset");
    chk(mac_valid, 1'b0, "R1", "mac_valid in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    do @(negedge clk); while (!mac_valid);
    chk(wide_addr, wide_exp, "R8", "width detect");
    chk(mac_addr, exp_mac(), "R9", "station address");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 4951) ^ 42435);
    do_reset(16'h8129, 1'b1);
    do_read(8'h00);
    do_read(8'hFF);
    do_read(8'h5A);
    do_read(8'h81);
    // R7: second start while busy must not disturb the first read
    @(posedge clk); #1 start = 1'b1; addr = 8'h33;
    @(posedge clk); #1 start = 1'b0;
    repeat (20) @(posedge clk);
    #1 start = 1'b1; addr = 8'h44;
    @(posedge clk); #1 start = 1'b0; addr = 8'h00;
    wait_done();
    chk(rdata, mem[8'h33], "R7", "result after ignored start");
    repeat (5) begin
      @(negedge clk);
      chk(ee_cs, 1'b0, "R7", "no extra read");
    end
    do_reset(16'h1234, 1'b0);
    do_read(8'h3F);
    do_read(8'hC5);
    chk(rdata, mem[5], "R3", "upper address bits dropped");
    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule